// File: doc/BRIEF.md
# Bit-Slice Eight-Bit ALU

This block is a purely combinational arithmetic logic unit for two eight-bit operands. A three-bit operation code chooses among four bitwise functions (AND, OR, NAND, NOR), two's-complement add and subtract, and a signed set-on-less-than compare. The outputs are an eight-bit result and a signed overflow flag.

The datapath is a row of identical one-bit slices. Each slice can invert either of its operand bits through a two-input XOR. It contains an AND gate, an OR gate and a full adder, and a four-way select picks the slice output from those three or from an external "less" bit. NAND and NOR come from De Morgan's laws: both operands are inverted, and then OR or AND is selected. A small decoder turns the operation code into the shared slice controls. A second small circuit takes the carries around the top slice and that slice's adder sum, and forms the overflow flag and the compare bit that feeds slice 0. The compare bit is corrected for overflow, so set-on-less-than is right for every operand pair.

Top module: `bslice_alu`

## Requirements
- R1: With op 0, the result is the bitwise AND of a and b.
- R2: With op 1, the result is the bitwise OR of a and b.
- R3: With op 2, the result is the bitwise NAND of a and b.
- R4: With op 3, the result is the bitwise NOR of a and b.
- R5: With op 4, the result is a + b modulo 256.
- R6: With op 5, the result is a - b modulo 256.
- R7: With op 4, overflow is 1 exactly when the signed sum of a and b lies outside -128..127.
- R8: With op 5, overflow is 1 exactly when the signed difference a - b lies outside -128..127.
- R9: With op 6, result bit 0 is 1 exactly when a is less than b, both read as signed two's-complement values. This holds for every pair, including pairs where a - b overflows.
- R10: With op 6, result bits 7 to 1 are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 8 | First operand |
| b_i | input | 8 | Second operand |
| op_i | input | 3 | Operation code, 0 to 6 (7 is never applied) |
| res_o | output | 8 | Result |
| ovf_o | output | 1 | Signed overflow, meaningful for add and subtract |

## Verification
Two functions can meet in the same evaluation. The subtraction overflow fires, and at the same moment the slice-7 sum has the wrong sign, which the compare bit must correct. The sweep produces this on purpose with every operand pair, including 0x80 against 0x7F and 0x7F against 0x80, under op 6. Bit 0 is judged against a compare of the operands as signed integers. Under op 5 the same pairs have their overflow judged against a range test on the integer difference.

// File: rtl/bslice_alu_pkg.sv
package bslice_alu_pkg;

  typedef enum logic [2:0] {
    OP_AND  = 3'd0,
    OP_OR   = 3'd1,
    OP_NAND = 3'd2,
    OP_NOR  = 3'd3,
    OP_ADD  = 3'd4,
    OP_SUB  = 3'd5,
    OP_SLT  = 3'd6,
    OP_RSVD = 3'd7
  } alu_op_e;

  typedef enum logic [1:0] {
    SEL_AND  = 2'd0,
    SEL_OR   = 2'd1,
    SEL_SUM  = 2'd2,
    SEL_LESS = 2'd3
  } slice_sel_e;

  typedef struct packed {
    logic       inv_a;
    logic       inv_b;
    logic       cin0;
    slice_sel_e sel;
  } slice_ctrl_t;

endpackage

// File: rtl/alu_ctrl_decode.sv
module alu_ctrl_decode
  import bslice_alu_pkg::*;
(
  input  logic [2:0]  op_i,
  output slice_ctrl_t ctrl_o
);

  alu_op_e op_w;
  assign op_w = alu_op_e'(op_i);

  always_comb begin
    ctrl_o = '{inv_a: 1'b0, inv_b: 1'b0, cin0: 1'b0, sel: SEL_AND};
    unique case (op_w)
      OP_AND:  ctrl_o.sel = SEL_AND;
      OP_OR:   ctrl_o.sel = SEL_OR;
      OP_NAND: begin
        ctrl_o.inv_a = 1'b1;
        ctrl_o.inv_b = 1'b1;
        ctrl_o.sel   = SEL_OR;
      end
      OP_NOR: begin
        ctrl_o.inv_a = 1'b1;
        ctrl_o.inv_b = 1'b1;
        ctrl_o.sel   = SEL_AND;
      end
      OP_ADD:  ctrl_o.sel = SEL_SUM;
      OP_SUB: begin
        ctrl_o.inv_b = 1'b1;
        ctrl_o.cin0  = 1'b1;
        ctrl_o.sel   = SEL_SUM;
      end
      OP_SLT: begin
        ctrl_o.inv_b = 1'b1;
        ctrl_o.cin0  = 1'b1;
        ctrl_o.sel   = SEL_LESS;
      end
      default: ctrl_o.sel = SEL_AND;
    endcase
  end

endmodule

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
  import bslice_alu_pkg::*;
(
  input  logic       a_i,
  input  logic       b_i,
  input  logic       less_i,
  input  logic       inv_a_i,
  input  logic       inv_b_i,
  input  logic       cin_i,
  input  slice_sel_e sel_i,
  output logic       res_o,
  output logic       cout_o,
  output logic       sign_o
);

  logic a_x, b_x, sum_w;

  assign a_x    = a_i ^ inv_a_i;
  assign b_x    = b_i ^ inv_b_i;
  assign sum_w  = a_x ^ b_x ^ cin_i;
  assign cout_o = (a_x & b_x) | (a_x & cin_i) | (b_x & cin_i);
  assign sign_o = sum_w;

  always_comb begin
    unique case (sel_i)
      SEL_AND:  res_o = a_x & b_x;
      SEL_OR:   res_o = a_x | b_x;
      SEL_SUM:  res_o = sum_w;
      SEL_LESS: res_o = less_i;
      default:  res_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/alu_slt_ovf.sv
module alu_slt_ovf (
  input  logic msb_sign_i,
  input  logic c_into_msb_i,
  input  logic c_out_msb_i,
  output logic ovf_o,
  output logic less0_o
);

  assign ovf_o   = c_into_msb_i ^ c_out_msb_i;
  // A set overflow flag means the top sum bit carries the wrong sign.
  assign less0_o = msb_sign_i ^ ovf_o;

endmodule

// File: rtl/bslice_alu.sv
module bslice_alu
  import bslice_alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [2:0]       op_i,
  output logic [WIDTH-1:0] res_o,
  output logic             ovf_o
);

  localparam int MSB = WIDTH - 1;

  slice_ctrl_t      ctrl_w;
  logic [WIDTH:0]   carry_w;
  logic [WIDTH-1:0] less_w;
  logic [WIDTH-1:0] sign_w;
  logic             less0_w;

  alu_ctrl_decode u_dec (
    .op_i   (op_i),
    .ctrl_o (ctrl_w)
  );

  assign carry_w[0] = ctrl_w.cin0;

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    if (i == 0) begin : g_lsb
      assign less_w[i] = less0_w;
    end else begin : g_upper
      assign less_w[i] = 1'b0;
    end

    alu_bit_slice u_slice (
      .a_i     (a_i[i]),
      .b_i     (b_i[i]),
      .less_i  (less_w[i]),
      .inv_a_i (ctrl_w.inv_a),
      .inv_b_i (ctrl_w.inv_b),
      .cin_i   (carry_w[i]),
      .sel_i   (ctrl_w.sel),
      .res_o   (res_o[i]),
      .cout_o  (carry_w[i+1]),
      .sign_o  (sign_w[i])
    );
  end

  alu_slt_ovf u_flag (
    .msb_sign_i   (sign_w[MSB]),
    .c_into_msb_i (carry_w[MSB]),
    .c_out_msb_i  (carry_w[WIDTH]),
    .ovf_o        (ovf_o),
    .less0_o      (less0_w)
  );

  // Checks on the assembled row of slices.
  always_comb begin
    if (op_i == 3'(OP_SLT)) begin
      p_slt_upper_zero_r10: assert (res_o[MSB:1] == '0)
        else $error("upper bits nonzero under compare");
      p_slt_signed_r9: assert (res_o[0] == ($signed(a_i) < $signed(b_i)))
        else $error("compare bit wrong");
    end
    if (op_i == 3'(OP_ADD)) begin
      p_sum_sign_r5: assert (sign_w == res_o)
        else $error("slice sums disagree with result");
      p_add_ovf_r7: assert (ovf_o == ((a_i[MSB] == b_i[MSB]) && (res_o[MSB] != a_i[MSB])))
        else $error("add overflow wrong");
    end
    if (op_i == 3'(OP_SUB)) begin
      p_sub_ovf_r8: assert (ovf_o == ((a_i[MSB] != b_i[MSB]) && (res_o[MSB] != a_i[MSB])))
        else $error("sub overflow wrong");
    end
    if (op_i == 3'(OP_NAND)) begin
      p_nand_r3: assert (res_o == ~(a_i & b_i))
        else $error("nand wrong");
    end
  end

endmodule

// File: tb/bslice_alu_test.sv
`timescale 1ns/100ps
module bslice_alu_test;

  localparam real CLK_PERIOD = 10.0;
  localparam int  WATCHDOG_CYCLES = 120000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] a, b;
  logic [2:0] op;
  logic [7:0] res;
  logic       ovf;
  int         n_checks = 0;
  int         n_fails = 0;
  bit         finished = 1'b0;

  always #(CLK_PERIOD / 2.0) clk = ~clk;

  bslice_alu uut (
    .a_i   (a),
    .b_i   (b),
    .op_i  (op),
    .res_o (res),
    .ovf_o (ovf)
  );

  task automatic check(string req, logic [7:0] got, logic [7:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s op=%0d a=%02h b=%02h got=%02h exp=%02h", req, op, a, b, got, exp);
    end
  endtask

  task automatic apply_and_check(logic [2:0] o, logic [7:0] x, logic [7:0] y);
    int sa, sb, r;
    op = o; a = x; b = y;
    #1;
    sa = int'($signed(x));
    sb = int'($signed(y));
    case (o)
      3'd0: check("R1", res, x & y);
      3'd1: check("R2", res, x | y);
      3'd2: check("R3", res, ~(x & y));
      3'd3: check("R4", res, ~(x | y));
      3'd4: begin
        r = sa + sb;
        check("R5", res, 8'(x + y));
        check("R7", {7'd0, ovf}, {7'd0, (r > 127 || r < -128)});
      end
      3'd5: begin
        r = sa - sb;
        check("R6", res, 8'(x - y));
        check("R8", {7'd0, ovf}, {7'd0, (r > 127 || r < -128)});
      end
      default: begin
        check("R9", {7'd0, res[0]}, {7'd0, (sa < sb)});
        check("R10", {1'b0, res[7:1]}, 8'd0);
      end
    endcase
  endtask

  initial begin
    a = '0; b = '0; op = '0;
    #0.5;
    #(CLK_PERIOD * 2);
    rst_n = 1'b1;
    // Idle state: AND of zeros, no overflow.
    check("R1", res, 8'h00);
    check("R7", {7'd0, ovf}, 8'd0);
    // Extreme pairings first, including overflowing compares (R9).
    foreach (uut.res_o[k]) begin end
    for (int o = 0; o < 7; o++) begin
      for (int i = 0; i < 4; i++) begin
        for (int j = 0; j < 4; j++) begin
          logic [7:0] ex [4];
          ex = '{8'h7F, 8'h80, 8'hFF, 8'h00};
          apply_and_check(3'(o), ex[i], ex[j]);
        end
      end
    end
    // Exhaustive sweep of every op and operand pair.
    for (int o = 0; o < 7; o++) begin
      for (int x = 0; x < 256; x++) begin
        for (int y = 0; y < 256; y++) begin
          apply_and_check(3'(o), 8'(x), 8'(y));
        end
      end
    end
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog expired before sweep end");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

endmodule